// File: doc/BRIEF.md
# Serial Result Port for a 16-bit Sampling Converter

This block is the digital pin side of a successive-approximation converter. A conversion result arrives on a parallel bus. The block presents that result to a host one bit at a time over four wires: a conversion-start strobe (`cnv`), a serial clock (`sck`), a serial input (`sdi`) and a serial output (`sdo`). Analog sampling is not part of the block. A down-counter stands in for the conversion phase, and `conv_data` is captured on the cycle that phase ends.

Each conversion-start edge also fixes how the port behaves until the next one. The `sdi` level just before the edge selects one of two modes. In select mode the output drives only while the port is addressed. In cascade mode `sdo` always drives, and after this port's own bits it passes on whatever enters `sdi`, so several ports can be wired in series as one long shift register. A leading low start bit can be placed before the data, so the host learns from `sdo` that a result is ready. In select mode this start bit is chosen by the pin levels at the end of the conversion. In cascade mode it is chosen by the `sck` level at the start edge.

The FSM has three states. `ST_IDLE` is the state after reset, with nothing to read. `ST_CONV` is the conversion phase. `ST_READ` means the result is loaded and being shifted out. The transitions are:
- `ST_IDLE` to `ST_CONV` on a start edge.
- `ST_CONV` to `ST_READ` when the conversion timer expires.
- `ST_READ` to `ST_CONV` on the next start edge.

Start edges seen in `ST_CONV` are dropped. All pins are sampled on `clk`. An edge is a change between the registered previous level and the present level.

Top module: `sar_serial_port`

## Requirements
- R1: After reset `idle` is 1, `sdo_oe` is 0, `sdo` is 0, and the port is in select mode.
- R2: A rising edge on `cnv` in `ST_IDLE` or `ST_READ` drops `idle` at the next clock. `idle` then stays 0 for exactly `CONV_CYCLES` cycles and returns to 1 when the result is loaded.
- R3: A rising edge on `cnv` while `idle` is 0 is ignored, and the conversion still ends `CONV_CYCLES` cycles after the accepted edge.
- R4: The `sdi` level in the clock cycle before the accepted `cnv` edge picks the mode: 1 selects select mode, 0 selects cascade mode. When `sdi` and `cnv` rise together, cascade mode is chosen. In cascade mode `sdo_oe` is 1 at all times from that edge on.
- R5: In select mode `sdo_oe` is 0 in `ST_IDLE` and `ST_CONV`. In `ST_READ` it equals (`cnv`==0 or `sdi`==0).
- R6: In select mode, if `cnv` or `sdi` is 0 on the clock that ends the conversion, `sdo` is 0 (the start bit) until the first `sck` falling edge, and the data MSB follows.
- R7: When no start bit is chosen, `sdo` presents data bit 15 as soon as the result is loaded.
- R8: In cascade mode, a start bit is chosen when `sck` is 1 in the cycle before the accepted `cnv` edge.
- R9: Each `sck` falling edge in `ST_READ` advances `sdo` by one bit, MSB first. `sdo` changes only on such an advance or at result load. In select mode, advances happen only while the port is addressed.
- R10: In cascade mode, after the 16 data bits (17 with a start bit), `sdo` repeats the `sdi` levels that were present at each falling edge, in order. In select mode, 0 follows the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Conversion-start strobe; also the select line in 3-wire use |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Mode strap, select line in 4-wire use, or upstream data in cascade |
| conv_data | input | 16 | Parallel result captured at conversion end |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output-driver enable; 0 models high impedance |
| idle | output | 1 | 1 whenever no conversion is running |

## Verification
A `cnv` rise driven before clock edge k lowers `idle` after edge k. It loads the result after edge k+`CONV_CYCLES`. The bench therefore samples `idle` at every falling clock edge in that window and expects the change exactly at step `CONV_CYCLES`. An `sck` fall is detected one clock after `sck` drops. The new `sdo` bit is therefore read at the falling clock edge that follows that detecting edge, one full sample per serial bit. `sdo_oe` depends directly on `cnv` and `sdi` and is read in the same half cycle they change. Mode and start-bit straps are held for a whole cycle before the start edge, because the port registers them.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } port_state_t;

    typedef enum logic {
        MODE_SELECT  = 1'b0,
        MODE_CASCADE = 1'b1
    } port_mode_t;

endpackage

// File: rtl/sar_pin_sampler.sv
module sar_pin_sampler #(
    parameter int N_PINS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_now,
    output logic [N_PINS-1:0] pin_prev,
    output logic [N_PINS-1:0] pin_rise,
    output logic [N_PINS-1:0] pin_fall
);

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_prev[g] <= 1'b0;
            end else begin
                pin_prev[g] <= pin_now[g];
            end
        end
        assign pin_rise[g] = pin_now[g] & ~pin_prev[g];
        assign pin_fall[g] = ~pin_now[g] & pin_prev[g];
    end

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] remain;
    logic             running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
        end else if (start) begin
            remain  <= LOAD_VAL;
            running <= 1'b1;
        end else if (running) begin
            if (remain == '0) begin
                running <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign done = running && (remain == '0);

endmodule

// File: rtl/sar_out_shifter.sv
module sar_out_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lead_bit,
    input  logic [DATA_W-1:0] data,
    input  logic              advance,
    input  logic              in_bit,
    output logic              sdo
);

    localparam int SH_W = DATA_W + 1;

    logic [SH_W-1:0] sh;
    logic            lead_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            lead_q <= 1'b0;
        end else if (load) begin
            sh     <= {1'b0, data};
            lead_q <= lead_bit;
        end else if (advance) begin
            sh     <= {sh[SH_W-2:0], in_bit};
        end
    end

    // With a start bit the tap sits one place higher, so the chain
    // input always surfaces right after the last own bit.
    assign sdo = lead_q ? sh[SH_W-1] : sh[SH_W-2];

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_port_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              idle
);

    localparam int PIN_CNV = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 2;
    localparam int N_PINS  = 3;

    port_state_t state, nxt;
    port_mode_t  mode_q;
    logic        cascade_lead_q;

    logic [N_PINS-1:0] pin_prev, pin_rise, pin_fall;
    logic cnv_rise, sck_fall, sdi_prev, sck_prev;
    logic start, done, load, shift_en, addressed, chain_mode, lead_sel;

    sar_pin_sampler #(.N_PINS(N_PINS)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_now  ({sdi, sck, cnv}),
        .pin_prev (pin_prev),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall)
    );

    assign cnv_rise = pin_rise[PIN_CNV];
    assign sck_fall = pin_fall[PIN_SCK];
    assign sck_prev = pin_prev[PIN_SCK];
    assign sdi_prev = pin_prev[PIN_SDI];

    sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (done)
    );

    assign chain_mode = (mode_q == MODE_CASCADE);
    assign addressed  = !(cnv && sdi);
    assign lead_sel   = chain_mode ? cascade_lead_q : addressed;

    sar_out_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .lead_bit (lead_sel),
        .data     (conv_data),
        .advance  (shift_en),
        .in_bit   (chain_mode & sdi),
        .sdo      (sdo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // straps captured at an accepted start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q         <= MODE_SELECT;
            cascade_lead_q <= 1'b0;
        end else if (start) begin
            mode_q         <= sdi_prev ? MODE_SELECT : MODE_CASCADE;
            cascade_lead_q <= sck_prev;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cnv_rise) nxt = ST_CONV;
            ST_CONV: if (done)     nxt = ST_READ;
            ST_READ: if (cnv_rise) nxt = ST_CONV;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        start    = 1'b0;
        load     = 1'b0;
        shift_en = 1'b0;
        idle     = 1'b1;
        sdo_oe   = chain_mode;
        unique case (state)
            ST_IDLE: begin
                start = cnv_rise;
            end
            ST_CONV: begin
                idle = 1'b0;
                load = done;
            end
            ST_READ: begin
                start    = cnv_rise;
                shift_en = sck_fall && (chain_mode || addressed);
                sdo_oe   = chain_mode || addressed;
            end
            default: begin
                idle = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
    parameter int CONV_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic idle,
    input logic sdo,
    input logic sdo_oe,
    input logic shift_en,
    input logic chain_mode
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (idle) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_run + 1;
        end
    end

    // R2
    conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(cnv));

    // R3
    conv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (busy_run < CONV_CYCLES));

    // R3
    conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> (busy_run == CONV_CYCLES));

    // R4
    cascade_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode |-> sdo_oe);

    // R5
    select_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !chain_mode) |-> !sdo_oe);

    // R9
    sdo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> ($past(shift_en) || $rose(idle)));

endmodule

bind sar_serial_port sar_serial_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnv        (cnv),
    .idle       (idle),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .shift_en   (shift_en),
    .chain_mode (chain_mode)
);

// File: tb/test_sar_serial_port.sv
module test_sar_serial_port;

    localparam int TB_CONV = 20;
    localparam int TB_W    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b1;
    logic [TB_W-1:0] conv_data = '0;
    logic sdo, sdo_oe, idle;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sar_serial_port #(.DATA_W(TB_W), .CONV_CYCLES(TB_CONV)) i_sar_serial_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv       (cnv),
        .sck       (sck),
        .sdi       (sdi),
        .conv_data (conv_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .idle      (idle)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start a conversion; check idle and sdo_oe across the whole window.
    task automatic run_conv(input string req, input bit exp_chain, input bit tie,
                            input bit cnv_after, input bit sdi_after, input bit sck_after,
                            input int restart_at);
        @(negedge clk);
        cnv = 1'b1;
        if (tie) sdi = 1'b1;
        for (int j = 0; j <= TB_CONV; j++) begin
            @(negedge clk);
            if (j < TB_CONV) begin
                check({req, " R2 idle low"}, idle, 0);
                check({req, " R4/R5 oe during conversion"}, sdo_oe, exp_chain);
            end else begin
                check({req, " R2/R3 idle back"}, idle, 1);
            end
            if (j == 0) begin
                cnv = cnv_after;
                sdi = sdi_after;
                sck = sck_after;
            end
            if (restart_at > 0 && j == restart_at - 1) cnv = 1'b0;
            if (restart_at > 0 && j == restart_at)     cnv = 1'b1;
        end
    endtask

    function automatic logic exp_bit(input int n, input bit chain, input bit lead,
                                     input logic [TB_W-1:0] d, input logic [TB_W-1:0] feed);
        int own = lead ? TB_W + 1 : TB_W;
        int di  = lead ? n - 1 : n;
        int k;
        if (lead && n == 0) return 1'b0;
        if (di >= 0 && di < TB_W) return d[TB_W-1-di];
        if (!chain) return 1'b0;
        k = n - own + 1;
        return feed[TB_W-1-((k-1) % TB_W)];
    endfunction

    // Sample 0 is checked at once; each pulse then checks one more bit.
    task automatic run_stream(input string req, input int npulses, input bit chain,
                              input bit lead, input logic [TB_W-1:0] d,
                              input logic [TB_W-1:0] feed);
        check({req, " R6/R7/R8 first sdo"}, sdo, exp_bit(0, chain, lead, d, feed));
        for (int n = 1; n <= npulses; n++) begin
            sck = 1'b1;
            if (chain) sdi = feed[TB_W-1-((n-1) % TB_W)];
            @(negedge clk);
            sck = 1'b0;
            @(negedge clk);
            check($sformatf("%s R9/R10 bit %0d", req, n), sdo, exp_bit(n, chain, lead, d, feed));
        end
    endtask

    task automatic t_reset;
        check("R1 idle", idle, 1);
        check("R1 oe", sdo_oe, 0);
        check("R1 sdo", sdo, 0);
    endtask

    task automatic t_select_3wire_plain;
        conv_data = 16'hB38D;
        sdi = 1'b1; cnv = 1'b0; sck = 1'b0;
        @(negedge clk);
        run_conv("3w plain", 0, 0, 1, 1, 0, 0);
        check("R5 unaddressed oe", sdo_oe, 0);
        cnv = 1'b0;
        @(negedge clk);
        check("R5 addressed oe", sdo_oe, 1);
        run_stream("3w plain", 18, 0, 0, conv_data, '0);
    endtask

    task automatic t_select_3wire_busy;
        conv_data = 16'h4E71;
        sdi = 1'b1; cnv = 1'b0;
        @(negedge clk);
        run_conv("3w busy", 0, 0, 0, 1, 0, 0);
        check("R6 oe at end", sdo_oe, 1);
        run_stream("3w busy R6", 18, 0, 1, conv_data, '0);
    endtask

    task automatic t_select_4wire;
        conv_data = 16'h9A0F;
        sdi = 1'b1; cnv = 1'b0;
        @(negedge clk);
        run_conv("4w", 0, 0, 1, 1, 0, 0);
        check("R5 4w unselected", sdo_oe, 0);
        // pulses while unaddressed must not advance the data (R9)
        sck = 1'b1; @(negedge clk); sck = 1'b0; @(negedge clk);
        sdi = 1'b0;
        @(negedge clk);
        check("R5 4w selected", sdo_oe, 1);
        run_stream("4w", 6, 0, 0, conv_data, '0);
        sdi = 1'b1;
        @(negedge clk);
        check("R5 4w deselected", sdo_oe, 0);
    endtask

    task automatic t_ignore_restart;
        conv_data = 16'h0123;
        sdi = 1'b1; cnv = 1'b0;
        @(negedge clk);
        run_conv("R3 restart", 0, 0, 0, 1, 0, 4);
        check("R3 no start bit after ignored edge", sdo_oe, 0);
        cnv = 1'b0;
        @(negedge clk);
        run_stream("R3 data", 2, 0, 0, conv_data, '0);
    endtask

    task automatic t_cascade_busy;
        conv_data = 16'hC5A3;
        sdi = 1'b0; cnv = 1'b0; sck = 1'b1;
        @(negedge clk);
        run_conv("R8 cascade", 1, 0, 0, 0, 0, 0);
        check("R4 cascade oe", sdo_oe, 1);
        run_stream("R10 cascade busy", 34, 1, 1, conv_data, 16'h6D29);
    endtask

    task automatic t_cascade_tied;
        conv_data = 16'h8E17;
        sdi = 1'b0; cnv = 1'b0; sck = 1'b0;
        @(negedge clk);
        run_conv("R4 tied", 1, 1, 1, 1, 0, 0);
        run_stream("R10 cascade plain", 33, 1, 0, conv_data, 16'hF0A5);
    endtask

    task automatic t_back_to_select;
        conv_data = 16'h7FFE;
        sdi = 1'b1; cnv = 1'b0; sck = 1'b0;
        @(negedge clk);
        run_conv("R4 back to select", 0, 0, 0, 1, 0, 0);
        run_stream("R6 again", 3, 0, 1, conv_data, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_3wire_plain();
        t_select_3wire_busy();
        t_select_4wire();
        t_ignore_restart();
        t_cascade_busy();
        t_cascade_tied();
        t_back_to_select();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule